// File: doc/BRIEF.md
# Double-Buffered Blanking Packet Slot Store

This block holds up to fifteen auxiliary data packets that a video transmitter inserts during blanking. Each packet occupies a slot of nine 32-bit words. Word 0 carries the four header bytes, packed with header byte k in bits 8k+7:8k. Words 1 to 8 carry the body. Software reaches the storage through a small write-only register bus. It selects a flat word address (slot times nine plus word) in an index register and then streams words through a data port. Each data-port write advances the address by one.

Every slot exists twice. Software fills a shadow copy, and the transmitter reads an active copy through its own read port. Software arms a slot by setting its update-request bit. The whole slot moves from shadow to active in a single edge, on the first frame-update pulse that arrives while the update lock is low. Until that edge the transmitter sees the previous packet. The request bit clears itself when the move completes, so software can poll it. A sticky conflict flag records any data-port write that lands in the slot the transmitter is reading in the same cycle. Writing 1 to the status register clears the flag.

Top module: `pkt_slot_store`

## Requirements
- R1: After reset the index is 0, no update request is pending, the conflict flag is 0, and every active word reads as 0.
- R2: A register write with regAddr=0 and a value below 135 loads that value into the index one cycle later. A value of 135 or above is ignored and leaves the index unchanged.
- R3: A register write with regAddr=1 stores regWrData into the shadow word at the current index and advances the index by one. The index wraps from 134 to 0.
- R4: Shadow writes do not change the active copy. The transmitter reads the old active contents until a transfer takes place.
- R5: A register write with regAddr=2 sets updatePending[s] for each bit s of regWrData[14:0] that is 1. Bits that are 0 leave the pending state unchanged.
- R6: A frame-update pulse with the lock at 0 copies all nine shadow words of every pending slot into its active copy on that edge, and clears those pending bits on the same edge. Slots that are not pending keep their active contents.
- R7: A frame-update pulse while the lock is 1 moves nothing, and all pending bits are retained.
- R8: With rdEn high, rdData shows the active word addressed by rdSlot and rdWord one cycle later. A slot of 15 or above, or a word of 9 or above, reads as 0. With rdEn low, rdData holds its value.
- R9: The conflict flag sets when a data-port write and a transmitter read (rdEn) hit the same slot in the same cycle. A write to a different slot does not set it.
- R10: The conflict flag stays set until a register write with regAddr=3 and bit 0 equal to 1. A write to that register with bit 0 equal to 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 index, 1 data, 2 update request, 3 status clear |
| regWrData | input | 32 | Register write data |
| frameUpdate | input | 1 | Frame-update event pulse |
| updateLock | input | 1 | Blocks transfers while 1 |
| rdEn | input | 1 | Transmitter read strobe |
| rdSlot | input | 4 | Transmitter read slot |
| rdWord | input | 4 | Transmitter read word within slot |
| rdData | output | 32 | Registered active-copy read data |
| curIndex | output | 8 | Current flat word index |
| updatePending | output | 15 | Per-slot armed transfer requests |
| conflictFlag | output | 1 | Sticky read/write collision flag |

## Verification
Every result in this block is due exactly one edge after the stimulus that causes it. The index, the pending bits and the conflict flag all update on the edge that captures the register write or the frame pulse, and rdData updates on the edge that captures rdEn. The active copy changes on the frame edge, so a read issued in the next cycle returns the new words one edge after that. The bench drives every input on the falling edge and checks outputs on the following falling edge, half a period after the edge that produced them. It sweeps all 135 word addresses and reads back every active word after each transfer.

// File: rtl/pss_pkg.sv
package pss_pkg;
  parameter int NUM_SLOTS      = 15;
  parameter int WORDS_PER_SLOT = 9;
  parameter int DATA_W         = 32;
  localparam int TOTAL_WORDS   = NUM_SLOTS * WORDS_PER_SLOT;
  localparam int SLOT_W        = $clog2(NUM_SLOTS + 1);
  localparam int WORD_W        = $clog2(WORDS_PER_SLOT + 1);
  localparam int IDX_W         = $clog2(TOTAL_WORDS);

  typedef enum logic [1:0] {
    SEL_INDEX  = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_UPDREQ = 2'd2,
    SEL_STATUS = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                  dataWe;
    logic [SLOT_W-1:0]     wrSlot;
    logic [WORD_W-1:0]     wrWord;
    logic [NUM_SLOTS-1:0]  xfer;
  } pssStrobe_t;
endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 frameUpdate,
  input  logic                 updateLock,
  input  logic                 rdEn,
  input  logic [SLOT_W-1:0]    rdSlot,
  output pssStrobe_t           strobe,
  output logic [IDX_W-1:0]     curIndex,
  output logic [NUM_SLOTS-1:0] updatePending,
  output logic                 conflictFlag
);
  logic [SLOT_W-1:0]    slotIdx;
  logic [WORD_W-1:0]    wordIdx;
  logic [IDX_W-1:0]     idxVal;
  logic                 idxWr, dataWr, reqWr, clrWr, fire, hit;
  logic [NUM_SLOTS-1:0] xferMask, reqMask;

  // register decode
  always_comb begin
    idxVal  = regWrData[IDX_W-1:0];
    idxWr   = regWrEn && (regSel_e'(regAddr) == SEL_INDEX)
              && (regWrData < DATA_W'(TOTAL_WORDS));
    dataWr  = regWrEn && (regSel_e'(regAddr) == SEL_DATA);
    reqWr   = regWrEn && (regSel_e'(regAddr) == SEL_UPDREQ);
    clrWr   = regWrEn && (regSel_e'(regAddr) == SEL_STATUS) && regWrData[0];
    reqMask = reqWr ? regWrData[NUM_SLOTS-1:0] : '0;
    fire    = frameUpdate && !updateLock;
    xferMask = fire ? updatePending : '0;
    hit     = dataWr && rdEn && (rdSlot == slotIdx);
  end

  // index kept as slot/word pair, loaded from a flat address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
      wordIdx <= '0;
    end else if (idxWr) begin
      slotIdx <= SLOT_W'(idxVal / IDX_W'(WORDS_PER_SLOT));
      wordIdx <= WORD_W'(idxVal % IDX_W'(WORDS_PER_SLOT));
    end else if (dataWr) begin
      if (wordIdx == WORD_W'(WORDS_PER_SLOT - 1)) begin
        wordIdx <= '0;
        slotIdx <= (slotIdx == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slotIdx + 1'b1;
      end else begin
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  // armed transfers: cleared by the edge that performs them
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updatePending <= '0;
    else       updatePending <= (updatePending & ~xferMask) | reqMask;
  end

  // sticky collision flag; a new collision wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      conflictFlag <= 1'b0;
    else if (hit)   conflictFlag <= 1'b1;
    else if (clrWr) conflictFlag <= 1'b0;
  end

  always_comb begin
    curIndex      = IDX_W'(slotIdx) * IDX_W'(WORDS_PER_SLOT) + IDX_W'(wordIdx);
    strobe.dataWe = dataWr;
    strobe.wrSlot = slotIdx;
    strobe.wrWord = wordIdx;
    strobe.xfer   = xferMask;
  end
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pssStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [WORD_W-1:0] rdWord,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slotRd;
  logic                             wordOk;
  logic                             slotOk;

  assign wordOk = rdWord < WORD_W'(WORDS_PER_SLOT);
  assign slotOk = rdSlot < SLOT_W'(NUM_SLOTS);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] shadowW [WORDS_PER_SLOT];
    logic [DATA_W-1:0] activeW [WORDS_PER_SLOT];

    always_ff @(posedge clk) begin
      if (strobe.dataWe && (strobe.wrSlot == SLOT_W'(s)))
        shadowW[strobe.wrWord] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS_PER_SLOT; w++) activeW[w] <= '0;
      end else if (strobe.xfer[s]) begin
        for (int w = 0; w < WORDS_PER_SLOT; w++) activeW[w] <= shadowW[w];
      end
    end

    assign slotRd[s] = wordOk ? activeW[rdWord] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= slotOk ? slotRd[rdSlot] : '0;
  end
endmodule

// File: rtl/pkt_slot_store.sv
module pkt_slot_store
  import pss_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 frameUpdate,
  input  logic                 updateLock,
  input  logic                 rdEn,
  input  logic [SLOT_W-1:0]    rdSlot,
  input  logic [WORD_W-1:0]    rdWord,
  output logic [DATA_W-1:0]    rdData,
  output logic [IDX_W-1:0]     curIndex,
  output logic [NUM_SLOTS-1:0] updatePending,
  output logic                 conflictFlag
);
  pssStrobe_t strobe;

  pss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameUpdate(frameUpdate), .updateLock(updateLock),
    .rdEn(rdEn), .rdSlot(rdSlot), .strobe(strobe), .curIndex(curIndex),
    .updatePending(updatePending), .conflictFlag(conflictFlag)
  );

  pss_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .rdEn(rdEn), .rdSlot(rdSlot), .rdWord(rdWord), .rdData(rdData)
  );
endmodule

// File: rtl/pss_chk.sv
module pss_chk
  import pss_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [1:0]           regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic                 frameUpdate,
  input logic                 updateLock,
  input logic                 rdEn,
  input logic [SLOT_W-1:0]    rdSlot,
  input logic [IDX_W-1:0]     curIndex,
  input logic [NUM_SLOTS-1:0] updatePending,
  input logic                 conflictFlag
);
  logic idxBad, dataW, reqW, clrW, fireNow;
  assign idxBad  = regWrEn && regAddr == 2'd0 && regWrData >= DATA_W'(TOTAL_WORDS);
  assign dataW   = regWrEn && regAddr == 2'd1;
  assign reqW    = regWrEn && regAddr == 2'd2;
  assign clrW    = regWrEn && regAddr == 2'd3 && regWrData[0];
  assign fireNow = frameUpdate && !updateLock;

  // R2
  idx_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxBad |=> $stable(curIndex));
  // R3
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataW && curIndex != IDX_W'(TOTAL_WORDS - 1) |=> curIndex == $past(curIndex) + 1'b1);
  // R3
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataW && curIndex == IDX_W'(TOTAL_WORDS - 1) |=> curIndex == '0);
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    fireNow && !reqW |=> updatePending == '0);
  // R7
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fireNow |=> (($past(updatePending) & ~updatePending) == '0));
  // R9
  conflict_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataW && rdEn && IDX_W'(rdSlot) == curIndex / IDX_W'(WORDS_PER_SLOT) |=> conflictFlag);
  // R10
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflictFlag && !clrW |=> conflictFlag);
  // R1
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !conflictFlag && !dataW |=> !conflictFlag);
endmodule

bind pkt_slot_store pss_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .frameUpdate(frameUpdate), .updateLock(updateLock),
  .rdEn(rdEn), .rdSlot(rdSlot), .curIndex(curIndex),
  .updatePending(updatePending), .conflictFlag(conflictFlag)
);

// File: tb/pkt_slot_store_bench.sv
module pkt_slot_store_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        frameUpdate = 1'b0;
  logic        updateLock = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdSlot = '0;
  logic [3:0]  rdWord = '0;
  logic [31:0] rdData;
  logic [7:0]  curIndex;
  logic [14:0] updatePending;
  logic        conflictFlag;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pkt_slot_store u_pkt_slot_store (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge; outputs are sampled at the next falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic re, input logic [3:0] s, input logic [3:0] w,
                      input logic fu, input logic lk);
    regWrEn = we; regAddr = a; regWrData = d;
    rdEn = re; rdSlot = s; rdWord = w;
    frameUpdate = fu; updateLock = lk;
    @(negedge clk);
    regWrEn = 1'b0; rdEn = 1'b0; frameUpdate = 1'b0; updateLock = 1'b0;
  endtask

  task automatic regWr(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0);
  endtask

  task automatic rdAct(input int s, input int w, output logic [31:0] q);
    step(1'b0, 2'd0, 32'd0, 1'b1, 4'(s), 4'(w), 1'b0, 1'b0);
    q = rdData;
  endtask

  function automatic logic [31:0] pat(input int g, input int s, input int w);
    // word 0 is a header: HB0..HB3 in byte lanes 0..3
    return {8'(g), 8'(s), 8'(w), 8'(s * 9 + w) ^ 8'h5A};
  endfunction

  task automatic fillAll(input int g);
    regWr(2'd0, 32'd0);
    for (int i = 0; i < 135; i++) begin
      regWr(2'd1, pat(g, i / 9, i % 9));
      check("R3 index advance", 32'(curIndex), 32'((i + 1) % 135));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 index", 32'(curIndex), 0);
    check("R1 pending", 32'(updatePending), 0);
    check("R1 conflict", 32'(conflictFlag), 0);
    check("R1 rdData", rdData, 0);
    for (int s = 0; s < 15; s++) begin
      rdAct(s, s % 9, q);
      check("R1 active zero", q, 0);
    end

    // R2 index load and ignored values
    regWr(2'd0, 32'd50);  check("R2 load 50", 32'(curIndex), 50);
    regWr(2'd0, 32'd135); check("R2 ignore 135", 32'(curIndex), 50);
    regWr(2'd0, 32'd255); check("R2 ignore 255", 32'(curIndex), 50);
    regWr(2'd0, 32'h100); check("R2 ignore 256", 32'(curIndex), 50);
    regWr(2'd0, 32'd134); check("R2 load 134", 32'(curIndex), 134);

    // R3 full sweep with wrap, then one more write past the end
    fillAll(1);
    regWr(2'd1, pat(1, 0, 0));
    check("R3 wrap reuse", 32'(curIndex), 1);

    // R4 active untouched by shadow writes
    for (int i = 0; i < 135; i++) begin
      rdAct(i / 9, i % 9, q);
      check("R4 active still zero", q, 0);
    end

    // R5 request bits
    regWr(2'd2, 32'd0);      check("R5 zero request", 32'(updatePending), 0);
    regWr(2'd2, 32'h2AAA);   check("R5 set odd", 32'(updatePending), 32'h2AAA);
    regWr(2'd2, 32'h0);      check("R5 zero keeps", 32'(updatePending), 32'h2AAA);

    // R7 locked frame event
    step(1'b0, 2'd0, 0, 1'b0, 0, 0, 1'b1, 1'b1);
    check("R7 pending kept", 32'(updatePending), 32'h2AAA);
    rdAct(1, 0, q); check("R7 no move", q, 0);

    // R6 unlocked frame event
    step(1'b0, 2'd0, 0, 1'b0, 0, 0, 1'b1, 1'b0);
    check("R6 pending cleared", 32'(updatePending), 0);
    for (int i = 0; i < 135; i++) begin
      rdAct(i / 9, i % 9, q);
      check("R6 odd slots moved", q, ((i / 9) % 2 == 1) ? pat(1, i / 9, i % 9) : 32'd0);
    end

    // second generation: shadow rewritten, active odd slots keep gen 1
    fillAll(2);
    for (int s = 1; s < 15; s += 2) begin
      rdAct(s, 8, q); check("R4 old active kept", q, pat(1, s, 8));
    end
    regWr(2'd2, 32'h7FFF);
    step(1'b0, 2'd0, 0, 1'b0, 0, 0, 1'b1, 1'b0);
    check("R6 all cleared", 32'(updatePending), 0);
    for (int i = 0; i < 135; i++) begin
      rdAct(i / 9, i % 9, q);
      check("R6 all moved", q, pat(2, i / 9, i % 9));
    end

    // R8 out-of-range reads and hold
    rdAct(15, 0, q); check("R8 slot 15", q, 0);
    rdAct(3, 9, q);  check("R8 word 9", q, 0);
    rdAct(3, 15, q); check("R8 word 15", q, 0);
    rdAct(7, 4, held);
    check("R8 read", held, pat(2, 7, 4));
    step(1'b0, 2'd0, 0, 1'b0, 4'd2, 4'd2, 1'b0, 1'b0);
    step(1'b0, 2'd0, 0, 1'b0, 4'd5, 4'd1, 1'b0, 1'b0);
    check("R8 hold", rdData, held);

    // R9 collision on different slot: no flag
    regWr(2'd0, 32'd45);
    step(1'b1, 2'd1, 32'hDEAD0001, 1'b1, 4'd6, 4'd0, 1'b0, 1'b0);
    check("R9 other slot", 32'(conflictFlag), 0);
    // R9 collision on same slot
    regWr(2'd0, 32'd38);
    step(1'b1, 2'd1, 32'hDEAD0002, 1'b1, 4'd4, 4'd3, 1'b0, 1'b0);
    check("R9 same slot", 32'(conflictFlag), 1);
    // R10 clear semantics
    regWr(2'd3, 32'h0);  check("R10 zero no clear", 32'(conflictFlag), 1);
    regWr(2'd1, 32'h1);  check("R10 sticky", 32'(conflictFlag), 1);
    regWr(2'd3, 32'h1);  check("R10 clear", 32'(conflictFlag), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule